// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit is a 32-bit co-processor that sits beside the integer datapath of a small processor core. It executes the basic bit-manipulation operations: inverted-operand logic, minimum and maximum, sign and zero extension, per-byte OR-combine, byte reversal, leading and trailing zero counts, population count, and rotates. The core pulses `start_i` with an operation code and operands. The unit answers with a one-cycle `done_o` strobe and a 32-bit result, which it holds until the next operation completes. If the code is not in the supported set, the unit raises `unsupported_o` instead.

A build-time parameter, `FAST_SHIFT`, picks the engine for the shift-like group (counts and rotates). With `FAST_SHIFT = 0` that group runs bit-serially, one bit position per cycle, to save area. With `FAST_SHIFT = 1` it uses a double-width shifter and parallel counters, and its latency is fixed. All other operations have a fixed short latency in both builds. A start pulse is accepted only while the unit is idle, and that includes the cycle in which `done_o` is high.

Top module: `bitmanip_unit`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `result_o` is 0, `done_o` is 0 and `unsupported_o` is 0 until the first operation completes.
- R2: Logic codes: 0 gives rs1 AND NOT rs2, 1 gives rs1 OR NOT rs2, 2 gives NOT (rs1 XOR rs2).
- R3: Min/max codes: 9 gives the signed maximum, 10 the unsigned maximum, 11 the signed minimum and 12 the unsigned minimum of rs1 and rs2.
- R4: Misc codes, each acting on rs1: 13 sign-extends bit 7, 14 sign-extends bit 15, 15 zero-extends the low halfword, 16 maps every nonzero byte to 0xFF and every zero byte to 0x00, and 17 reverses the byte order.
- R5: Count codes, each acting on rs1: 3 counts leading zeros, 4 counts trailing zeros and 5 counts set bits. A zero operand gives 32 for both zero counts, and the population count ranges from 0 to 32.
- R6: Rotate codes: 6 rotates rs1 left and 7 rotates it right, in both cases by rs2[4:0]. Code 8 rotates rs1 right by `imm_i`. Higher bits of rs2 are ignored, and an amount of 0 returns rs1 unchanged.
- R7: Codes 0–2 and 9–31 raise `done_o` exactly 3 cycles after the cycle in which `start_i` was sampled.
- R8: With `FAST_SHIFT = 1`, codes 3–8 finish in 4 cycles. With `FAST_SHIFT = 0`, rotates take 4 plus the rotate amount, leading and trailing zero counts take 4 plus the returned count, and population count takes 36.
- R9: Codes 18–31 complete with `unsupported_o` high and `result_o` equal to 0. Supported codes complete with `unsupported_o` low.
- R10: `done_o` is high for exactly one cycle. `unsupported_o` is high only together with `done_o`. `result_o` changes only in a cycle where `done_o` is high.
- R11: A `start_i` pulse that arrives while an operation is in progress is ignored. The running operation keeps its result and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 5 | Operation code, sampled with start |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source operand / rotate amount |
| imm_i | input | 5 | Rotate amount for the immediate rotate |
| result_o | output | 32 | Result, held until the next completion |
| done_o | output | 1 | One-cycle completion strobe |
| unsupported_o | output | 1 | Unsupported code, high with done |

## Verification
Cycle counts are taken from the cycle in which `start_i` is high. The result is due in cycle 3 for the logic, min/max, misc and unsupported codes, and in cycle 4 for the shift-like codes in the fast build. In the serial build it is due in cycle 4 plus the rotate amount or the zero count, and in cycle 36 for the population count. The bench drives the iterative and the fast builds side by side with the same stimulus. It samples on falling edges and records the first falling edge at which each build shows `done_o`. It compares that index against latency figures computed from the operands. After `done_o`, it waits further cycles to confirm that the strobe has dropped and that the result has not moved.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int XLEN  = 32;
    localparam int OPW   = 5;
    localparam int CNTW  = $clog2(XLEN) + 1;
    localparam int SHW   = $clog2(XLEN);
    localparam int NBYTE = XLEN / 8;

    localparam logic [OPW-1:0] OP_ANDN  = 5'd0;
    localparam logic [OPW-1:0] OP_ORN   = 5'd1;
    localparam logic [OPW-1:0] OP_XNOR  = 5'd2;
    localparam logic [OPW-1:0] OP_CLZ   = 5'd3;
    localparam logic [OPW-1:0] OP_CTZ   = 5'd4;
    localparam logic [OPW-1:0] OP_CPOP  = 5'd5;
    localparam logic [OPW-1:0] OP_ROL   = 5'd6;
    localparam logic [OPW-1:0] OP_ROR   = 5'd7;
    localparam logic [OPW-1:0] OP_RORI  = 5'd8;
    localparam logic [OPW-1:0] OP_MAX   = 5'd9;
    localparam logic [OPW-1:0] OP_MAXU  = 5'd10;
    localparam logic [OPW-1:0] OP_MIN   = 5'd11;
    localparam logic [OPW-1:0] OP_MINU  = 5'd12;
    localparam logic [OPW-1:0] OP_SEXTB = 5'd13;
    localparam logic [OPW-1:0] OP_SEXTH = 5'd14;
    localparam logic [OPW-1:0] OP_ZEXTH = 5'd15;
    localparam logic [OPW-1:0] OP_ORCB  = 5'd16;
    localparam logic [OPW-1:0] OP_REV8  = 5'd17;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_RUN,
        ST_FIN
    } bmu_state_e;

    typedef struct packed {
        bmu_state_e        state;
        logic [OPW-1:0]    op;
        logic [XLEN-1:0]   work;
        logic [XLEN-1:0]   opb;
        logic [SHW-1:0]    shamt;
        logic [CNTW-1:0]   acc;
        logic [CNTW-1:0]   steps;
        logic [XLEN-1:0]   res;
        logic              done;
        logic              unsup;
    } bmu_regs_t;

    function automatic logic is_count_op(input logic [OPW-1:0] op);
        return (op == OP_CLZ) || (op == OP_CTZ) || (op == OP_CPOP);
    endfunction

    function automatic logic is_rot_op(input logic [OPW-1:0] op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RORI);
    endfunction

    function automatic logic is_shift_op(input logic [OPW-1:0] op);
        return is_count_op(op) || is_rot_op(op);
    endfunction

    function automatic logic [XLEN-1:0] bit_reverse(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = v[XLEN-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/bmu_simple_ops.sv
module bmu_simple_ops
    import bmu_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] y_o,
    output logic            hit_o
);

    logic [XLEN-1:0] orcb;
    logic [XLEN-1:0] rev8;
    logic            s_gt;
    logic            u_gt;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign orcb[8*i +: 8] = (|a_i[8*i +: 8]) ? 8'hFF : 8'h00;
        assign rev8[8*i +: 8] = a_i[XLEN-8-8*i +: 8];
    end

    assign s_gt = $signed(a_i) > $signed(b_i);
    assign u_gt = a_i > b_i;

    always_comb begin
        hit_o = 1'b1;
        y_o   = '0;
        case (op_i)
            OP_ANDN:  y_o = a_i & ~b_i;
            OP_ORN:   y_o = a_i | ~b_i;
            OP_XNOR:  y_o = ~(a_i ^ b_i);
            OP_MAX:   y_o = s_gt ? a_i : b_i;
            OP_MAXU:  y_o = u_gt ? a_i : b_i;
            OP_MIN:   y_o = s_gt ? b_i : a_i;
            OP_MINU:  y_o = u_gt ? b_i : a_i;
            OP_SEXTB: y_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
            OP_SEXTH: y_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
            OP_ZEXTH: y_o = {{(XLEN-16){1'b0}}, a_i[15:0]};
            OP_ORCB:  y_o = orcb;
            OP_REV8:  y_o = rev8;
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bmu_fast_shift.sv
module bmu_fast_shift
    import bmu_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW-1:0]  shamt_i,
    output logic [XLEN-1:0] rot_o,
    output logic [CNTW-1:0] cnt_o
);

    logic [2*XLEN-1:0] dbl_l;
    logic [2*XLEN-1:0] dbl_r;
    logic [CNTW-1:0]   lz;
    logic [CNTW-1:0]   tz;
    logic [CNTW-1:0]   pop;

    assign dbl_l = {a_i, a_i} << shamt_i;
    assign dbl_r = {a_i, a_i} >> shamt_i;
    assign rot_o = (op_i == OP_ROL) ? dbl_l[2*XLEN-1:XLEN] : dbl_r[XLEN-1:0];

    always_comb begin
        logic seen_l;
        logic seen_t;
        lz     = '0;
        tz     = '0;
        pop    = '0;
        seen_l = 1'b0;
        seen_t = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            seen_l = seen_l | a_i[XLEN-1-i];
            seen_t = seen_t | a_i[i];
            lz     = lz  + CNTW'(!seen_l);
            tz     = tz  + CNTW'(!seen_t);
            pop    = pop + CNTW'(a_i[i]);
        end
    end

    always_comb begin
        case (op_i)
            OP_CLZ:  cnt_o = lz;
            OP_CTZ:  cnt_o = tz;
            default: cnt_o = pop;
        endcase
    end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
    import bmu_pkg::*;
#(
    parameter bit FAST_SHIFT = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [4:0]      op_i,
    input  logic [31:0]     rs1_i,
    input  logic [31:0]     rs2_i,
    input  logic [4:0]      imm_i,
    output logic [31:0]     result_o,
    output logic            done_o,
    output logic            unsupported_o
);

    bmu_regs_t       q;
    bmu_regs_t       d;
    logic [XLEN-1:0] simple_y;
    logic            simple_hit;
    logic [XLEN-1:0] fast_rot;
    logic [CNTW-1:0] fast_cnt;

    bmu_simple_ops u_simple (
        .op_i  (q.op),
        .a_i   (q.work),
        .b_i   (q.opb),
        .y_o   (simple_y),
        .hit_o (simple_hit)
    );

    if (FAST_SHIFT) begin : g_par
        bmu_fast_shift u_fast (
            .op_i    (q.op),
            .a_i     (q.work),
            .shamt_i (q.shamt),
            .rot_o   (fast_rot),
            .cnt_o   (fast_cnt)
        );
    end else begin : g_ser
        assign fast_rot = '0;
        assign fast_cnt = '0;
    end

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                d.done  = 1'b0;
                d.unsup = 1'b0;
                if (start_i) begin
                    d.state = ST_PREP;
                    d.op    = op_i;
                    d.work  = rs1_i;
                    d.opb   = rs2_i;
                    d.shamt = (op_i == OP_RORI) ? imm_i : rs2_i[SHW-1:0];
                    d.acc   = '0;
                    d.steps = '0;
                end
            end
            ST_PREP: begin
                if (is_shift_op(q.op)) begin
                    d.state = ST_RUN;
                    if (FAST_SHIFT) begin
                        d.work = fast_rot;
                        d.acc  = fast_cnt;
                    end else if (is_rot_op(q.op)) begin
                        d.acc = CNTW'(q.shamt);
                    end else if (q.op == OP_CTZ) begin
                        d.work = bit_reverse(q.work);
                    end
                end else begin
                    d.state = ST_FIN;
                    d.work  = simple_hit ? simple_y : '0;
                end
            end
            ST_RUN: begin
                if (FAST_SHIFT) begin
                    d.state = ST_FIN;
                end else if (is_rot_op(q.op)) begin
                    if (q.acc == '0) begin
                        d.state = ST_FIN;
                    end else begin
                        d.acc  = q.acc - 1'b1;
                        d.work = (q.op == OP_ROL) ? {q.work[XLEN-2:0], q.work[XLEN-1]}
                                                  : {q.work[0], q.work[XLEN-1:1]};
                    end
                end else if (q.op == OP_CPOP) begin
                    if (q.steps == CNTW'(XLEN)) begin
                        d.state = ST_FIN;
                    end else begin
                        d.acc   = q.acc + CNTW'(q.work[XLEN-1]);
                        d.work  = q.work << 1;
                        d.steps = q.steps + 1'b1;
                    end
                end else begin
                    if (q.work[XLEN-1] || (q.acc == CNTW'(XLEN))) begin
                        d.state = ST_FIN;
                    end else begin
                        d.acc  = q.acc + 1'b1;
                        d.work = q.work << 1;
                    end
                end
            end
            ST_FIN: begin
                d.state = ST_IDLE;
                d.done  = 1'b1;
                d.unsup = !simple_hit && !is_shift_op(q.op);
                d.res   = is_count_op(q.op) ? XLEN'(q.acc) : q.work;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign result_o      = q.res;
    assign done_o        = q.done;
    assign unsupported_o = q.unsup;

endmodule

// File: rtl/bmu_chk.sv
module bmu_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        done_i,
    input logic        unsup_i,
    input logic [31:0] result_i
);

    // R10
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    // R10
    unsup_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unsup_i |-> done_i);

    // R9
    unsup_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unsup_i |-> (result_i == 32'd0));

    // R10
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |-> $stable(result_i));

endmodule

bind bitmanip_unit bmu_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done_o),
    .unsup_i  (unsupported_o),
    .result_i (result_o)
);

// File: tb/bitmanip_unit_tb.sv
module bitmanip_unit_tb;

    localparam logic [4:0] C_ANDN = 5'd0,  C_ORN = 5'd1,  C_XNOR = 5'd2;
    localparam logic [4:0] C_CLZ  = 5'd3,  C_CTZ = 5'd4,  C_CPOP = 5'd5;
    localparam logic [4:0] C_ROL  = 5'd6,  C_ROR = 5'd7,  C_RORI = 5'd8;
    localparam logic [4:0] C_MAX  = 5'd9,  C_MAXU = 5'd10, C_MIN = 5'd11, C_MINU = 5'd12;
    localparam logic [4:0] C_SEXTB = 5'd13, C_SEXTH = 5'd14, C_ZEXTH = 5'd15;
    localparam logic [4:0] C_ORCB = 5'd16, C_REV8 = 5'd17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic [4:0]  imm = '0;
    logic [31:0] res_s, res_f;
    logic        done_s, done_f, uns_s, uns_f;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bitmanip_unit #(.FAST_SHIFT(1'b0)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm),
        .result_o(res_s), .done_o(done_s), .unsupported_o(uns_s)
    );

    bitmanip_unit #(.FAST_SHIFT(1'b1)) u_fast (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm),
        .result_o(res_f), .done_o(done_f), .unsupported_o(uns_f)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_res(input logic [4:0] o, input logic [31:0] a,
                                            input logic [31:0] b, input logic [4:0] im);
        logic [31:0] r;
        int          n;
        bit          stop;
        r = '0;
        case (o)
            C_ANDN: r = a & ~b;
            C_ORN:  r = a | ~b;
            C_XNOR: r = ~(a ^ b);
            C_CLZ: begin
                n = 0; stop = 0;
                for (int i = 31; i >= 0; i--) begin
                    if (a[i]) stop = 1;
                    if (!stop) n++;
                end
                r = 32'(n);
            end
            C_CTZ: begin
                n = 0; stop = 0;
                for (int i = 0; i < 32; i++) begin
                    if (a[i]) stop = 1;
                    if (!stop) n++;
                end
                r = 32'(n);
            end
            C_CPOP: begin
                n = 0;
                for (int i = 0; i < 32; i++) n += int'(a[i]);
                r = 32'(n);
            end
            C_ROL: begin
                r = a;
                for (int i = 0; i < int'(b[4:0]); i++) r = {r[30:0], r[31]};
            end
            C_ROR, C_RORI: begin
                r = a;
                for (int i = 0; i < int'((o == C_RORI) ? im : b[4:0]); i++) r = {r[0], r[31:1]};
            end
            C_MAX:   r = ($signed(a) > $signed(b)) ? a : b;
            C_MAXU:  r = (a > b) ? a : b;
            C_MIN:   r = ($signed(a) < $signed(b)) ? a : b;
            C_MINU:  r = (a < b) ? a : b;
            C_SEXTB: r = {{24{a[7]}}, a[7:0]};
            C_SEXTH: r = {{16{a[15]}}, a[15:0]};
            C_ZEXTH: r = {16'h0, a[15:0]};
            C_ORCB:  for (int i = 0; i < 4; i++) r[8*i +: 8] = (a[8*i +: 8] != 0) ? 8'hFF : 8'h00;
            C_REV8:  r = {a[7:0], a[15:8], a[23:16], a[31:24]};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic int ref_lat(input logic [4:0] o, input logic [31:0] a,
                                   input logic [31:0] b, input logic [4:0] im, input bit fast);
        if (o < C_CLZ || o > C_RORI) return 3;
        if (fast) return 4;
        case (o)
            C_ROL, C_ROR: return 4 + int'(b[4:0]);
            C_RORI:       return 4 + int'(im);
            C_CPOP:       return 36;
            default:      return 4 + int'(ref_res(o, a, b, im));
        endcase
    endfunction

    // Drives one operation (optionally with an interfering start at cycle 2) and checks both builds.
    task automatic run_op(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] im, input string req, input bit poke);
        int lat_s = 0, lat_f = 0;
        logic [31:0] r_s = '0, r_f = '0;
        logic u_s = 0, u_f = 0;
        logic [31:0] exp_r;
        bit exp_u;
        @(negedge clk);
        start = 1'b1; op = o; rs1 = a; rs2 = b; imm = im;
        for (int k = 1; k <= 80 && (lat_s == 0 || lat_f == 0); k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke && k == 2) begin
                start = 1'b1; op = C_ANDN; rs1 = '1; rs2 = '0;
            end
            if (poke && k == 3) start = 1'b0;
            if (done_s && lat_s == 0) begin lat_s = k; r_s = res_s; u_s = uns_s; end
            if (done_f && lat_f == 0) begin lat_f = k; r_f = res_f; u_f = uns_f; end
        end
        exp_r = ref_res(o, a, b, im);
        exp_u = (o > C_REV8);
        chk(r_s == exp_r, req, $sformatf("iter result op %0d", o), r_s, exp_r);
        chk(r_f == exp_r, req, $sformatf("fast result op %0d", o), r_f, exp_r);
        chk(lat_s == ref_lat(o, a, b, im, 0), (o >= C_CLZ && o <= C_RORI) ? "R8" : "R7",
            $sformatf("iter latency op %0d", o), 32'(lat_s), 32'(ref_lat(o, a, b, im, 0)));
        chk(lat_f == ref_lat(o, a, b, im, 1), (o >= C_CLZ && o <= C_RORI) ? "R8" : "R7",
            $sformatf("fast latency op %0d", o), 32'(lat_f), 32'(ref_lat(o, a, b, im, 1)));
        chk(u_s == exp_u && u_f == exp_u, "R9", "unsupported flag", {30'd0, u_s, u_f},
            {30'd0, exp_u, exp_u});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_s == 0 && !done_s && !uns_s && res_f == 0 && !done_f && !uns_f, "R1",
            "outputs in reset", {res_s[29:0], done_s, uns_s}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(res_s == 0 && !done_s && !uns_s && res_f == 0 && !done_f && !uns_f, "R1",
            "outputs after reset", {res_s[29:0], done_s, uns_s}, 32'd0);
    endtask

    task automatic t_logic;
        run_op(C_ANDN, 32'hF0F0_1234, 32'h0FF0_00FF, 0, "R2", 0);
        run_op(C_ORN,  32'h0000_0001, 32'hFFFF_0000, 0, "R2", 0);
        run_op(C_XNOR, 32'hA5A5_5A5A, 32'hFFFF_0000, 0, "R2", 0);
    endtask

    task automatic t_minmax;
        run_op(C_MAX,  32'h8000_0000, 32'h0000_0001, 0, "R3", 0);
        run_op(C_MAXU, 32'h8000_0000, 32'h0000_0001, 0, "R3", 0);
        run_op(C_MIN,  32'h8000_0000, 32'h0000_0001, 0, "R3", 0);
        run_op(C_MINU, 32'h8000_0000, 32'h0000_0001, 0, "R3", 0);
        run_op(C_MIN,  32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, "R3", 0);
    endtask

    task automatic t_misc;
        run_op(C_SEXTB, 32'h1234_5680, 0, 0, "R4", 0);
        run_op(C_SEXTH, 32'h0000_7FFF, 0, 0, "R4", 0);
        run_op(C_SEXTH, 32'h0000_8001, 0, 0, "R4", 0);
        run_op(C_ZEXTH, 32'hFFFF_8001, 0, 0, "R4", 0);
        run_op(C_ORCB,  32'h0100_8000, 0, 0, "R4", 0);
        run_op(C_REV8,  32'h1122_3344, 0, 0, "R4", 0);
    endtask

    task automatic t_count;
        run_op(C_CLZ,  32'h0000_0000, 0, 0, "R5", 0);
        run_op(C_CLZ,  32'h8000_0000, 0, 0, "R5", 0);
        run_op(C_CLZ,  32'h0001_0F00, 0, 0, "R5", 0);
        run_op(C_CTZ,  32'h0000_0000, 0, 0, "R5", 0);
        run_op(C_CTZ,  32'h0000_0001, 0, 0, "R5", 0);
        run_op(C_CTZ,  32'h8000_0000, 0, 0, "R5", 0);
        run_op(C_CPOP, 32'hFFFF_FFFF, 0, 0, "R5", 0);
        run_op(C_CPOP, 32'h0000_0000, 0, 0, "R5", 0);
        run_op(C_CPOP, 32'h8421_0F01, 0, 0, "R5", 0);
    endtask

    task automatic t_rotate;
        run_op(C_ROL,  32'h8000_0001, 32'h0000_0000, 5'd7, "R6", 0);
        run_op(C_ROL,  32'h8000_0001, 32'h0000_001F, 5'd0, "R6", 0);
        run_op(C_ROL,  32'h1234_5678, 32'hFFFF_FFE5, 5'd0, "R6", 0);
        run_op(C_ROR,  32'h1234_5678, 32'h0000_0024, 5'd3, "R6", 0);
        run_op(C_RORI, 32'h1234_5678, 32'h0000_0001, 5'd12, "R6", 0);
        run_op(C_RORI, 32'hDEAD_BEEF, 32'h0000_0009, 5'd0, "R6", 0);
    endtask

    task automatic t_unsupported;
        run_op(5'd18, 32'hFFFF_FFFF, 32'h1234_5678, 5'd3, "R9", 0);
        run_op(5'd31, 32'h0000_0001, 32'hFFFF_FFFF, 5'd31, "R9", 0);
        run_op(C_ANDN, 32'hFFFF_FFFF, 32'h0, 0, "R9", 0);
    endtask

    task automatic t_busy_hold;
        logic [31:0] keep_s, keep_f;
        run_op(C_CPOP, 32'hF0F0_0001, 0, 0, "R11", 1);
        keep_s = res_s;
        keep_f = res_f;
        repeat (3) @(negedge clk);
        chk(!done_s && !done_f, "R10", "done dropped after strobe", {30'd0, done_s, done_f}, 0);
        chk(res_s == keep_s && res_f == keep_f, "R10", "result held", res_s, keep_s);
        chk(keep_s == 32'd9, "R11", "ignored start left result", keep_s, 32'd9);
    endtask

    task automatic t_random;
        for (int i = 0; i < 30; i++) begin
            run_op(5'($urandom % 18), $urandom, $urandom, 5'($urandom), "R6", 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_logic();
        t_minmax();
        t_misc();
        t_count();
        t_rotate();
        t_unsupported();
        t_busy_hold();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule